// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block tracks approximate recency of use for every set of a set-associative cache and names the way to evict when a miss needs room. Each set owns a small binary tree of WAYS-1 decision bits. Every internal node splits the ways beneath it into a lower half and an upper half, and its bit records which half should be evicted next. The cache controller reports each hit or fill with an access strobe, a set index and a way number. The tree bits on the path to that way are turned to point at the other half, so the way just used cannot be chosen next.

When a miss occurs, the controller issues a query for a set and supplies the valid bits of that set's ways. An empty way is always preferred, and the lowest-numbered empty way is taken. If every way is valid, the victim is found by walking the tree from the root, going to the half each bit names. The answer is registered and appears one cycle after the query. Tag comparison, data storage and refill sequencing belong to the surrounding cache. With two ways the tree is a single bit per set, and the policy is then exact LRU.

Top module: `plru_victim_sel`

## Requirements
- R1: After reset every tree bit of every set is 0 and `vic_ok` is low. A query with all ways valid then returns way 0 for any set.
- R2: `vic_ok` is high in exactly the cycle after a cycle with `qry_en` high. In a cycle after `qry_en` was low, `vic_way` keeps its previous value.
- R3: If any bit of `qry_valid` is 0 (bit i is the valid flag of way i), the victim is the lowest i whose bit is 0, regardless of the tree.
- R4: With all ways valid, the victim is found by walking from node 0 (the root). Node n has node 2n+1 (lower half of its ways) and node 2n+2 (upper half) as children. A bit of 0 selects the lower half and a bit of 1 selects the upper half. With 8 ways, node 1 covers ways 0-3, node 2 covers ways 4-7, and nodes 3 to 6 each cover one pair.
- R5: An access sets every node on the path to the accessed way so that it points to the half not containing that way. Nodes off that path keep their values. A later all-valid query of that set never returns the accessed way.
- R6: An access to one set leaves the victim of every other set unchanged.
- R7: A query and an access to the same set in the same cycle return the victim computed from the state before that access.
- R8: While `acc_en` is low, `acc_set` and `acc_way` have no effect on any state.
- R9: With WAYS = 2, each set holds one bit, and the all-valid victim is always the way that was not accessed most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | A hit or fill happened this cycle |
| acc_set | input | $clog2(SETS) | Set of the access |
| acc_way | input | $clog2(WAYS) | Way that was hit or filled |
| qry_en | input | 1 | Victim query strobe |
| qry_set | input | $clog2(SETS) | Set being queried |
| qry_valid | input | WAYS | Valid bit of each way of the queried set |
| vic_way | output | $clog2(WAYS) | Registered victim way |
| vic_ok | output | 1 | `vic_way` answers the query of the previous cycle |

## Verification
The main instance is built with WAYS = 8 and SETS = 4. This makes a full three-level tree walk reachable, with every node from the root to the pair level exercised. It also lets accesses to two sets interleave while a third set stays untouched. A second instance with WAYS = 2 and SETS = 2 covers the one-bit case, where the policy must act as exact LRU. A hand-derived sequence over one 8-way set checks each tree walk against a precomputed way. A long pseudo-random run then compares the design against an independent model that splits way ranges in half.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Mark the path to 'way' so every node points to the other half.
  function automatic logic [63:0] tree_touch(logic [63:0] t, int unsigned way, int lg);
    logic [63:0] r;
    int unsigned node;
    logic dir;
    r = t;
    node = 0;
    for (int l = 0; l < 6; l++) begin
      if (l < lg) begin
        dir = 1'((way >> (lg - 1 - l)) & 1);
        r[node[5:0]] = ~dir;
        node = 2 * node + 1 + 32'(dir);
      end
    end
    return r;
  endfunction

  // Follow the stored bits from the root down to a leaf.
  function automatic int unsigned tree_pick(logic [63:0] t, int lg);
    int unsigned node;
    int unsigned way;
    logic dir;
    node = 0;
    way = 0;
    for (int l = 0; l < 6; l++) begin
      if (l < lg) begin
        dir = t[node[5:0]];
        way = (way << 1) | 32'(dir);
        node = 2 * node + 1 + 32'(dir);
      end
    end
    return way;
  endfunction

  // Index of the lowest cleared bit among the first 'ways' bits.
  function automatic int unsigned lowest_free(logic [63:0] m, int ways);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < ways && !m[i]) idx = 32'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store #(
  parameter int WAYS = 8,
  parameter int SETS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic [$clog2(SETS)-1:0]  acc_set,
  input  logic [$clog2(WAYS)-1:0]  acc_way,
  input  logic [$clog2(SETS)-1:0]  rd_set,
  output logic [WAYS-2:0]          rd_tree
);
  localparam int NB = WAYS - 1;
  localparam int LW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);

  logic [NB-1:0] tree_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [63:0] nxt_wide;
    logic        hit_set;
    assign hit_set  = acc_en && (acc_set == SW'(s));
    assign nxt_wide = plru_pkg::tree_touch({{(64-NB){1'b0}}, tree_q[s]}, 32'(acc_way), LW);
    always_ff @(posedge clk) begin
      if (!rst_n) tree_q[s] <= '0;
      else if (hit_set) tree_q[s] <= nxt_wide[NB-1:0];
    end
  end

  assign rd_tree = tree_q[rd_set];
endmodule

// File: rtl/plru_victim_pick.sv
module plru_victim_pick #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-2:0]         tree,
  input  logic [WAYS-1:0]         valid,
  output logic [$clog2(WAYS)-1:0] way,
  output logic                    any_free
);
  localparam int NB = WAYS - 1;
  localparam int LW = $clog2(WAYS);

  logic [LW-1:0] tree_way;
  logic [LW-1:0] free_way;

  assign any_free = ~&valid;
  assign tree_way = LW'(plru_pkg::tree_pick({{(64-NB){1'b0}}, tree}, LW));
  assign free_way = LW'(plru_pkg::lowest_free({{(64-WAYS){1'b1}}, valid}, WAYS));
  assign way      = any_free ? free_way : tree_way;
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
  parameter int WAYS = 8,
  parameter int SETS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic [$clog2(SETS)-1:0]  acc_set,
  input  logic [$clog2(WAYS)-1:0]  acc_way,
  input  logic                     qry_en,
  input  logic [$clog2(SETS)-1:0]  qry_set,
  input  logic [WAYS-1:0]          qry_valid,
  output logic [$clog2(WAYS)-1:0]  vic_way,
  output logic                     vic_ok
);
  localparam int LW = $clog2(WAYS);

  logic [WAYS-2:0] set_tree;
  logic [LW-1:0]   pick_way;
  logic            pick_free;

  plru_tree_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_set(acc_set),
    .acc_way(acc_way), .rd_set(qry_set), .rd_tree(set_tree)
  );

  plru_victim_pick #(.WAYS(WAYS)) u_pick (
    .tree(set_tree), .valid(qry_valid), .way(pick_way), .any_free(pick_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_ok  <= 1'b0;
      vic_way <= '0;
    end else begin
      vic_ok <= qry_en;
      if (qry_en) vic_way <= pick_way;
    end
  end
endmodule

// File: rtl/plru_victim_sel_chk.sv
module plru_victim_sel_chk #(
  parameter int WAYS = 8,
  parameter int SETS = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acc_en,
  input logic [$clog2(SETS)-1:0]  acc_set,
  input logic [$clog2(WAYS)-1:0]  acc_way,
  input logic                     qry_en,
  input logic [$clog2(SETS)-1:0]  qry_set,
  input logic [WAYS-1:0]          qry_valid,
  input logic [$clog2(WAYS)-1:0]  vic_way,
  input logic                     vic_ok,
  input logic                     pick_free
);
  AST_OK_AFTER_QUERY: assert property (@(posedge clk) disable iff (!rst_n) qry_en |=> vic_ok); // R2
  AST_OK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !qry_en |=> !vic_ok); // R2
  AST_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !qry_en |=> $stable(vic_way)); // R2
  AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_en && pick_free) |=> ((($past(qry_valid) >> vic_way) & WAYS'(1)) == '0)); // R3
  AST_FREE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_en && pick_free) |=>
      (($past(qry_valid) & ((WAYS'(1) << vic_way) - WAYS'(1))) == ((WAYS'(1) << vic_way) - WAYS'(1)))); // R3
  AST_RECENT_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_en) && qry_en && (&qry_valid) && qry_set == $past(acc_set)) |=>
      (vic_way != $past(acc_way, 2))); // R5
endmodule

bind plru_victim_sel plru_victim_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way),
  .qry_en(qry_en), .qry_set(qry_set), .qry_valid(qry_valid), .vic_way(vic_way),
  .vic_ok(vic_ok), .pick_free(pick_free)
);

// File: tb/plru_victim_sel_tb.sv
module plru_victim_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       acc_en = 0, qry_en = 0;
  logic [1:0] acc_set = 0, qry_set = 0;
  logic [2:0] acc_way = 0;
  logic [7:0] qry_valid = 8'hFF;
  logic [2:0] vic_way;
  logic       vic_ok;

  logic acc2_en = 0, acc2_set = 0, acc2_way = 0, qry2_en = 0, qry2_set = 0;
  logic [1:0] qry2_valid = 2'b11;
  logic vic2_way, vic2_ok;

  plru_victim_sel #(.WAYS(8), .SETS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way),
    .qry_en(qry_en), .qry_set(qry_set), .qry_valid(qry_valid),
    .vic_way(vic_way), .vic_ok(vic_ok));

  plru_victim_sel #(.WAYS(2), .SETS(2)) u_dut_w2 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc2_en), .acc_set(acc2_set), .acc_way(acc2_way),
    .qry_en(qry2_en), .qry_set(qry2_set), .qry_valid(qry2_valid),
    .vic_way(vic2_way), .vic_ok(vic2_ok));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {acc_en, acc_set, acc_way, qry_en, qry_set, qry_valid, expected way}
  localparam logic [19:0] VEC [17] = '{
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd0},
    {1'b1, 2'd1, 3'd0, 1'b0, 2'd0, 8'hFF, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd4},
    {1'b1, 2'd1, 3'd4, 1'b0, 2'd0, 8'hFF, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd2},
    {1'b1, 2'd1, 3'd2, 1'b0, 2'd0, 8'hFF, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd6},
    {1'b1, 2'd1, 3'd6, 1'b0, 2'd0, 8'hFF, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd1},
    {1'b1, 2'd1, 3'd1, 1'b1, 2'd1, 8'hFF, 3'd1},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd5},
    {1'b0, 2'd1, 3'd5, 1'b0, 2'd0, 8'hFF, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hFF, 3'd5},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'hDB, 3'd2},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd0, 8'hFF, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'h00, 3'd0},
    {1'b0, 2'd0, 3'd0, 1'b1, 2'd1, 8'h7F, 3'd7}
  };

  // Bench model: halve the way range at each level.
  logic [6:0] mdl [4];

  task automatic model_touch(int s, int w);
    int lo = 0, hi = 8, node = 0, mid;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (w < mid) begin mdl[s][node] = 1'b1; node = 2 * node + 1; hi = mid; end
      else begin mdl[s][node] = 1'b0; node = 2 * node + 2; lo = mid; end
    end
  endtask

  function automatic int model_pick(int s);
    int lo = 0, hi = 8, node = 0, mid;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (!mdl[s][node]) begin node = 2 * node + 1; hi = mid; end
      else begin node = 2 * node + 2; lo = mid; end
    end
    return lo;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    string tag;
    @(negedge clk);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 vic_ok low after reset", int'(vic_ok), 0);

    for (int i = 0; i < 17; i++) begin
      {acc_en, acc_set, acc_way, qry_en, qry_set, qry_valid} = VEC[i][19:3];
      tick();
      chk("R2 vic_ok follows query", int'(vic_ok), int'(VEC[i][13]));
      if (VEC[i][13]) begin
        case (i)
          0: tag = "R1";
          9: tag = "R7";
          12: tag = "R8";
          14: tag = "R6";
          13, 15, 16: tag = "R3";
          default: tag = "R4 R5";
        endcase
        chk({tag, " table victim"}, int'(vic_way), int'(VEC[i][2:0]));
      end
    end
    acc_en = 0; qry_en = 0;
    tick();
    chk("R2 vic_ok low without query", int'(vic_ok), 0);
    chk("R2 vic_way held", int'(vic_way), 7);

    rst_n = 1'b0; tick(); rst_n = 1'b1;
    qry_en = 1; qry_set = 1; qry_valid = 8'hFF;
    tick();
    chk("R1 reset clears tree", int'(vic_way), 0);
    qry_en = 0;
    for (int s = 0; s < 4; s++) mdl[s] = '0;

    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      int s, w, os;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = 2 + int'(lfsr[0]);
      w = int'(lfsr[3:1]);
      os = 5 - s;
      acc_en = 1; acc_set = 2'(s); acc_way = 3'(w); qry_en = 0;
      tick();
      model_touch(s, w);
      acc_en = 1; acc_set = 2'(os); acc_way = lfsr[6:4];
      qry_en = 1; qry_set = 2'(s); qry_valid = 8'hFF;
      tick();
      chk("R4 sweep victim vs model", int'(vic_way), model_pick(s));
      chk("R5 accessed way spared", int'(vic_way == 3'(w)), 0);
      model_touch(os, int'(lfsr[6:4]));
      acc_en = 0; qry_en = 0;
    end

    qry_en = 1; qry_set = 0; qry_valid = 8'hFF;
    tick();
    chk("R6 untouched set still way 0", int'(vic_way), 0);
    qry_en = 0;

    acc2_en = 1; acc2_set = 1; acc2_way = 0; tick();
    acc2_en = 0; qry2_en = 1; qry2_set = 1; tick();
    chk("R9 two-way victim after way 0", int'(vic2_way), 1);
    qry2_en = 0; acc2_en = 1; acc2_way = 1; tick();
    acc2_en = 0; qry2_en = 1; tick();
    chk("R9 two-way victim after way 1", int'(vic2_way), 0);
    qry2_set = 0; tick();
    chk("R9 two-way other set", int'(vic2_way), 0);
    qry2_en = 0;
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule